// File: doc/BRIEF.md
# Display Bridge Power-Up and Configuration Sequencer

This block brings an SPI-programmed display bridge out of power-off and loads its configuration with no processor involved. A single start pulse launches the work. The block raises the bridge supply enable and then steps the bridge reset line through a fixed timed pattern. Next it reads the bridge's identity word over SPI. If the word matches, it plays a constant configuration table and then signals completion.

Each table entry is 32 bits wide. An entry whose top byte is 0xFF is a wait: its low byte gives a time in milliseconds, and the block sends nothing on the bus for it. Any other entry is sent as one 24-bit SPI write, using bits 23:0. The first byte of that write tells the bridge what the frame is: 0x70 picks a register, or issues a bare command when the last byte is a command code, and 0x72 carries 16 bits of data. The table's length and contents are parameters. Millisecond timing comes from a parameterised divider of the system clock.

Top module: `boot_seq_top`

## Requirements
- R1: During and after reset, and before any start pulse, pwr_en_o is 0, bridge_nreset_o is 0, spi_cs_n_o is 1, spi_sclk_o is 1, and busy_o, done_o and error_o are all 0.
- R2: After start, pwr_en_o rises in the next cycle. Each of the following phases lasts N x CLK_PER_MS cycles, within 3 cycles: supply settle (10 ms) until bridge_nreset_o goes high, reset high (10 ms), reset low (200 ms), and reset high (200 ms) until the first chip-select falls.
- R3: The first frame is 0x7000B0, which selects the identity register at index 0xB0. The second frame sends 0x73 and then 16 more clocks. During those 16 clocks the identity word is shifted in from spi_miso_i, MSB first, sampled on rising SCLK edges.
- R4: If the identity word is not ID_VALUE (default 0x2828), error_o is set and busy_o falls. No table frame is sent and done_o never pulses.
- R5: A table entry with bits 31:24 equal to 0xFF sends no frame. It holds the walk for bits 7:0 milliseconds, and a count of 0 gives no wait.
- R6: Every other entry is sent in table order as exactly 24 SCLK cycles within one chip-select-low window, carrying bits 23:0 MSB first.
- R7: The SPI link uses clock mode 3. SCLK is high whenever chip select is high. MOSI changes only on falling SCLK edges. Every high or low SCLK level within a frame lasts SCLK_HALF clocks.
- R8: Chip select stays high for at least 2 x SCLK_HALF clocks between frames.
- R9: busy_o is high from the cycle after start until the sequence ends. done_o is a single-cycle pulse in the cycle busy_o falls after the last table entry, including when that entry is a delay.
- R10: A start pulse while busy_o is high has no effect on the frames, the timing or the number of done pulses.
- R11: A start after done or error reruns the whole sequence from the power-up step, and error_o is clear from the cycle after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| spi_miso_i | input | 1 | SPI data from the bridge |
| pwr_en_o | output | 1 | Bridge supply enable |
| bridge_nreset_o | output | 1 | Bridge reset line, low holds the bridge in reset |
| spi_sclk_o | output | 1 | SPI clock, idles high |
| spi_mosi_o | output | 1 | SPI data to the bridge |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the table has completed |
| error_o | output | 1 | Identity mismatch, held until the next start |

## Verification
The bench builds the block with CLK_PER_MS = 8 and SCLK_HALF = 2. This brings the 420 ms power-up and the per-entry waits down to a few thousand cycles, so several complete runs fit in one simulation. It also uses an 11-entry table produced by a bench function. That table holds eight write frames of both kinds and three delay entries of 1, 3 and 0 ms, the last of which ends the table. This makes the delay-only ending, the zero-length wait and the gap timing around waits reachable. The identity responses and the moment of the extra start pulse come from a seeded random source, so both the match and mismatch paths occur, along with restarts after each.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_RHI,
        ST_RLO,
        ST_SETTLE,
        ST_IDSEL,
        ST_IDRD,
        ST_FETCH,
        ST_SEND,
        ST_WAITD,
        ST_END,
        ST_FAIL
    } boot_st_e;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_SHIFT,
        SP_GAP
    } spi_st_e;

    // Leading byte codes understood by the bridge, and the table wait marker
    localparam logic [7:0] OP_SELECT = 8'h70;
    localparam logic [7:0] OP_READ   = 8'h73;
    localparam logic [7:0] OP_DELAY  = 8'hFF;

endpackage

// File: rtl/boot_ms_tick.sv
// Millisecond strobe: one-cycle pulse every DIV clocks, restartable
module boot_ms_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/boot_spi24.sv
// 24-bit mode-3 SPI master: shifts a frame out MSB first, shifts 24 bits in
module boot_spi24
    import boot_seq_pkg::*;
#(
    parameter int HALF = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic [23:0] frame_i,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        mosi_o,
    output logic        cs_n_o,
    output logic        done_o,
    output logic [15:0] rx_o
);
    localparam int CW = (HALF > 1) ? $clog2(2 * HALF) : 1;
    localparam logic [4:0] LAST_BIT = 5'd23;

    typedef struct packed {
        spi_st_e       st;
        logic [CW-1:0] cnt;
        logic [4:0]    nbit;
        logic [23:0]   tx;
        logic [23:0]   rx;
        logic          sclk;
        logic          csn;
        logic          done;
    } spi_regs_t;

    localparam spi_regs_t SPI_RST = '{
        st: SP_IDLE, cnt: '0, nbit: '0, tx: '0, rx: '0,
        sclk: 1'b1, csn: 1'b1, done: 1'b0
    };

    spi_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            SP_IDLE: begin
                if (go_i) begin
                    r_d.st   = SP_SHIFT;
                    r_d.tx   = frame_i;
                    r_d.csn  = 1'b0;
                    r_d.sclk = 1'b0;
                    r_d.nbit = '0;
                    r_d.cnt  = CW'(HALF - 1);
                end
            end
            SP_SHIFT: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (!r_q.sclk) begin
                    // rising edge: the bridge samples MOSI, we sample MISO
                    r_d.sclk = 1'b1;
                    r_d.rx   = {r_q.rx[22:0], miso_i};
                    r_d.cnt  = CW'(HALF - 1);
                end else if (r_q.nbit == LAST_BIT) begin
                    r_d.csn = 1'b1;
                    r_d.st  = SP_GAP;
                    r_d.cnt = CW'(2 * HALF - 1);
                end else begin
                    // falling edge: present the next bit
                    r_d.nbit = r_q.nbit + 5'd1;
                    r_d.tx   = {r_q.tx[22:0], 1'b0};
                    r_d.sclk = 1'b0;
                    r_d.cnt  = CW'(HALF - 1);
                end
            end
            SP_GAP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st   = SP_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d = SPI_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SPI_RST;
        else        r_q <= r_d;
    end

    assign sclk_o = r_q.sclk;
    assign cs_n_o = r_q.csn;
    assign mosi_o = r_q.tx[23];
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx[15:0];
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int          CLK_PER_MS = 50000,
    parameter int          SCLK_HALF  = 3,
    parameter int          PWR_MS     = 10,
    parameter int          RST_HI_MS  = 10,
    parameter int          RST_LO_MS  = 200,
    parameter int          SETTLE_MS  = 200,
    parameter logic [7:0]  ID_REG     = 8'hB0,
    parameter logic [15:0] ID_VALUE   = 16'h2828,
    parameter int          TABLE_LEN  = 4,
    parameter logic [32*TABLE_LEN-1:0] TABLE_BITS = {
        32'h0070_0029, 32'hFF00_0005, 32'h0072_0101, 32'h0070_00C0
    }
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic spi_miso_i,
    output logic pwr_en_o,
    output logic bridge_nreset_o,
    output logic spi_sclk_o,
    output logic spi_mosi_o,
    output logic spi_cs_n_o,
    output logic busy_o,
    output logic done_o,
    output logic error_o
);
    localparam int IDX_W = (TABLE_LEN > 1) ? $clog2(TABLE_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_LEN - 1);

    typedef struct packed {
        boot_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [7:0]       ms;
        logic             pwr;
        logic             nrst;
        logic             go;
        logic [23:0]      frame;
        logic             done;
        logic             err;
    } boot_regs_t;

    boot_regs_t  r_d, r_q;
    logic        tick, tick_clr;
    logic        spi_done;
    logic [15:0] spi_rx;
    logic [31:0] entry;
    logic        wait_over;

    // Unpack the constant table into entries
    logic [31:0] tbl [TABLE_LEN];
    for (genvar g = 0; g < TABLE_LEN; g++) begin : g_tbl
        assign tbl[g] = TABLE_BITS[32*g +: 32];
    end

    assign entry     = tbl[r_q.idx];
    assign wait_over = (r_q.ms == 8'd0);

    boot_ms_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    boot_spi24 #(.HALF(SCLK_HALF)) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (r_q.go),
        .frame_i (r_q.frame),
        .miso_i  (spi_miso_i),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .cs_n_o  (spi_cs_n_o),
        .done_o  (spi_done),
        .rx_o    (spi_rx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        tick_clr = 1'b0;

        case (r_q.st)
            ST_IDLE, ST_END, ST_FAIL: begin
                if (start_i) begin
                    r_d.st   = ST_PWR;
                    r_d.pwr  = 1'b1;
                    r_d.nrst = 1'b0;
                    r_d.err  = 1'b0;
                    r_d.ms   = 8'(PWR_MS);
                    tick_clr = 1'b1;
                end
            end
            ST_PWR: begin
                if (wait_over) begin
                    r_d.st   = ST_RHI;
                    r_d.nrst = 1'b1;
                    r_d.ms   = 8'(RST_HI_MS);
                    tick_clr = 1'b1;
                end else if (tick) begin
                    r_d.ms = r_q.ms - 8'd1;
                end
            end
            ST_RHI: begin
                if (wait_over) begin
                    r_d.st   = ST_RLO;
                    r_d.nrst = 1'b0;
                    r_d.ms   = 8'(RST_LO_MS);
                    tick_clr = 1'b1;
                end else if (tick) begin
                    r_d.ms = r_q.ms - 8'd1;
                end
            end
            ST_RLO: begin
                if (wait_over) begin
                    r_d.st   = ST_SETTLE;
                    r_d.nrst = 1'b1;
                    r_d.ms   = 8'(SETTLE_MS);
                    tick_clr = 1'b1;
                end else if (tick) begin
                    r_d.ms = r_q.ms - 8'd1;
                end
            end
            ST_SETTLE: begin
                if (wait_over) begin
                    r_d.st    = ST_IDSEL;
                    r_d.go    = 1'b1;
                    r_d.frame = {OP_SELECT, 8'h00, ID_REG};
                end else if (tick) begin
                    r_d.ms = r_q.ms - 8'd1;
                end
            end
            ST_IDSEL: begin
                if (spi_done) begin
                    r_d.st    = ST_IDRD;
                    r_d.go    = 1'b1;
                    r_d.frame = {OP_READ, 16'h0000};
                end
            end
            ST_IDRD: begin
                if (spi_done) begin
                    if (spi_rx == ID_VALUE) begin
                        r_d.st  = ST_FETCH;
                        r_d.idx = '0;
                    end else begin
                        r_d.st  = ST_FAIL;
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (entry[31:24] == OP_DELAY) begin
                    r_d.st   = ST_WAITD;
                    r_d.ms   = entry[7:0];
                    tick_clr = 1'b1;
                end else begin
                    r_d.st    = ST_SEND;
                    r_d.go    = 1'b1;
                    r_d.frame = entry[23:0];
                end
            end
            ST_SEND, ST_WAITD: begin
                if ((r_q.st == ST_SEND && spi_done) ||
                    (r_q.st == ST_WAITD && wait_over)) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st   = ST_END;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st  = ST_FETCH;
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else if (r_q.st == ST_WAITD && tick) begin
                    r_d.ms = r_q.ms - 8'd1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_en_o        = r_q.pwr;
    assign bridge_nreset_o = r_q.nrst;
    assign done_o          = r_q.done;
    assign error_o         = r_q.err;
    assign busy_o          = !(r_q.st == ST_IDLE || r_q.st == ST_END ||
                               r_q.st == ST_FAIL);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic spi_miso_i,
    input logic pwr_en_o,
    input logic bridge_nreset_o,
    input logic spi_sclk_o,
    input logic spi_mosi_o,
    input logic spi_cs_n_o,
    input logic busy_o,
    input logic done_o,
    input logic error_o
);
    // R7
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> spi_sclk_o);

    // R7
    mosi_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n_o && spi_sclk_o && $past(spi_sclk_o) && !$past(spi_cs_n_o))
        |-> $stable(spi_mosi_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    busy_drop_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || error_o));

    // R4
    error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (!busy_o && !done_o && spi_cs_n_o));

    // R2
    reset_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_nreset_o |-> pwr_en_o);

    // R1
    bus_quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_nreset_o |-> spi_cs_n_o);
endmodule

bind boot_seq_top boot_seq_chk u_chk (.*);

// File: tb/sim_boot_seq_top.sv
module sim_boot_seq_top;
    localparam int CPM   = 8;
    localparam int HALF  = 2;
    localparam int TL    = 11;
    localparam int LIMIT = 190000;

    function automatic logic [31:0] entry_of(input int i);
        if (i % 4 == 2)      return {8'hFF, 16'h0000, 8'((i * 3) % 5)};
        else if (i % 2 == 1) return {8'h00, 8'h72, 16'((i * 4919) ^ 165)};
        else                 return {8'h00, 8'h70, 8'h00, 8'(8'h11 + i)};
    endfunction

    function automatic logic [32*TL-1:0] build_tbl();
        logic [32*TL-1:0] t;
        t = '0;
        for (int i = 0; i < TL; i++) t[32*i +: 32] = entry_of(i);
        return t;
    endfunction

    localparam logic [32*TL-1:0] TBL = build_tbl();

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic miso, pwr, nrst, sclk, mosi, cs_n, busy, done, err;

    always #4 clk = ~clk; // 8-unit period: 125 MHz with 1 ns units

    boot_seq_top #(
        .CLK_PER_MS(CPM), .SCLK_HALF(HALF), .TABLE_LEN(TL), .TABLE_BITS(TBL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .spi_miso_i(miso),
        .pwr_en_o(pwr), .bridge_nreset_o(nrst), .spi_sclk_o(sclk),
        .spi_mosi_o(mosi), .spi_cs_n_o(cs_n), .busy_o(busy), .done_o(done),
        .error_o(err)
    );

    int n_chk = 0, n_fail = 0;
    bit fin = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected frames from the table model
    logic [23:0] exp_fr [TL];
    int          pre_ms [TL];
    int          pre_nd [TL];
    int          n_exp = 0;

    // Bridge model and monitors
    logic [15:0] id_resp = 16'h0;
    logic [23:0] rxsh = '0;
    int          pos_cnt = 24;
    logic [23:0] fr_log [16];
    int          fr_bits [16];
    int          cs_fall [16];
    int          nfr = 0, ndone = 0, nrise = 0;
    int          rise_t [2];
    int          fall_t = 0;
    int          cyc = 0;
    int          hi_run = 0, lv_run = 0;
    logic        p_nrst = 0, p_cs = 1, p_sclk = 1;

    assign miso = (pos_cnt < 24) ? {8'h00, id_resp}[23 - pos_cnt] : 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk) begin
        if (!cs_n) begin
            rxsh = {rxsh[22:0], mosi};
            pos_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (nrst && !p_nrst) begin
                if (nrise < 2) rise_t[nrise] = cyc;
                nrise++;
            end
            if (!nrst && p_nrst) fall_t = cyc;
            if (done) ndone++;
            if (!cs_n && p_cs) begin
                // R8 gap between frames
                chk(hi_run >= 2 * HALF, "R8 cs high gap", hi_run, 2 * HALF);
                if (nfr < 16) cs_fall[nfr] = cyc;
                rxsh = '0;
                pos_cnt = 0;
            end
            if (cs_n && !p_cs) begin
                if (nfr < 16) begin
                    fr_log[nfr]  = rxsh;
                    fr_bits[nfr] = pos_cnt;
                end
                nfr++;
            end
            hi_run = cs_n ? hi_run + 1 : 0;
            if (!cs_n && !p_cs) begin
                if (sclk == p_sclk) lv_run++;
                else begin
                    // R7 level width
                    chk(lv_run == HALF, "R7 sclk level width", lv_run, HALF);
                    lv_run = 1;
                end
            end else lv_run = 1;
        end
        p_nrst = nrst;
        p_cs   = cs_n;
        p_sclk = sclk;
    end

    task automatic run_seq(input logic [15:0] id, input bit poke);
        bit ok;
        int t0, d0, d, e;
        ok = (id == 16'h2828);
        id_resp = id;
        nfr = 0; ndone = 0; nrise = 0;
        @(negedge clk);
        start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        chk(err == 1'b0, "R11 error cleared on start", err, 0);
        chk(pwr == 1'b1, "R2 power enable after start", pwr, 1);
        if (poke) begin
            repeat ($urandom_range(2500, 50)) @(negedge clk);
            if (busy) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (busy) @(negedge clk);
        repeat (300) @(negedge clk);

        // R4 / R9 outcome
        chk(err == !ok, "R4 error flag", err, !ok);
        chk(ndone == (ok ? 1 : 0), "R9 done pulse count", ndone, ok ? 1 : 0);
        chk(busy == 1'b0, "R9 busy low at end", busy, 0);
        chk(nfr == (ok ? 2 + n_exp : 2), "R4 frame count", nfr, ok ? 2 + n_exp : 2);

        // R2 power-up timing
        chk(nrise >= 2, "R2 reset rises", nrise, 2);
        if (nrise >= 2) begin
            d = rise_t[0] - t0;
            chk(d >= 80 - 3 && d <= 80 + 3, "R2 supply settle", d, 80);
            d = fall_t - rise_t[0];
            chk(d >= 80 - 3 && d <= 80 + 3, "R2 reset high", d, 80);
            d = rise_t[1] - fall_t;
            chk(d >= 1600 - 3 && d <= 1600 + 3, "R2 reset low", d, 1600);
            d = cs_fall[0] - rise_t[1];
            chk(d >= 1600 - 3 && d <= 1600 + 3, "R2 reset settle", d, 1600);
        end

        // R3 identity frames
        chk(fr_log[0] == 24'h7000B0, "R3 select frame", fr_log[0], 24'h7000B0);
        chk(fr_log[1][23:16] == 8'h73, "R3 read opcode", fr_log[1][23:16], 8'h73);
        chk(fr_bits[1] == 24, "R3 read clocks", fr_bits[1], 24);

        if (ok && nfr == 2 + n_exp) begin
            d0 = cs_fall[3] - cs_fall[2];
            for (int k = 0; k < n_exp; k++) begin
                // R6 frame contents and length
                chk(fr_log[2 + k] == exp_fr[k], "R6 frame data", fr_log[2 + k], exp_fr[k]);
                chk(fr_bits[2 + k] == 24, "R6 frame clocks", fr_bits[2 + k], 24);
                if (k >= 1) begin
                    // R5 delay entries stretch the spacing by their ms count
                    d = cs_fall[2 + k] - cs_fall[1 + k];
                    e = d0 + pre_ms[k] * CPM + pre_nd[k] * 2;
                    chk(d >= e - 3 && d <= e + 3, "R5 delay spacing", d, e);
                end
            end
        end
    endtask

    initial begin
        int ms, nd, dummy;
        logic [15:0] id;
        dummy = $urandom(32'h5EED);
        ms = 0; nd = 0;
        for (int i = 0; i < TL; i++) begin
            if (entry_of(i)[31:24] == 8'hFF) begin
                ms += int'(entry_of(i)[7:0]);
                nd++;
            end else begin
                exp_fr[n_exp] = entry_of(i)[23:0];
                pre_ms[n_exp] = ms;
                pre_nd[n_exp] = nd;
                n_exp++;
                ms = 0; nd = 0;
            end
        end

        repeat (5) @(negedge clk);
        // R1 reset state
        chk({pwr, nrst, cs_n, sclk, busy, done, err} == 7'b0011000,
            "R1 outputs in reset", {pwr, nrst, cs_n, sclk, busy, done, err}, 7'b0011000);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk({pwr, nrst, cs_n, sclk, busy, done, err} == 7'b0011000,
            "R1 outputs before start", {pwr, nrst, cs_n, sclk, busy, done, err}, 7'b0011000);

        run_seq(16'h2828, 1'b0);           // main path
        id = 16'($urandom);
        if (id == 16'h2828) id = 16'h2829;
        run_seq(id, 1'b0);                 // R4 mismatch
        run_seq(16'h2828, 1'b1);           // R10 and R11: restart, extra start
        run_seq(16'h2808, 1'b1);           // single-bit mismatch
        for (int r = 0; r < 2; r++) begin
            id = ($urandom_range(1, 0) == 1) ? 16'h2828 : 16'($urandom);
            run_seq(id, 1'b1);
        end
        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual busy=%0d expected sequence end", busy);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule